// File: doc/BRIEF.md
# I2C GPIO Expander Register Core

This block is an eight-pin general-purpose I/O expander that a host drives over an I2C target interface. The host writes a command byte that selects one of four 8-bit registers. It then either writes data bytes into that register or reads the register back after a repeated START. Each pin is either driven from the output register or left as an input, and the configuration register picks which for each pin. A read of the input port returns the live pin levels, and each bit can be flipped by a per-bit inversion mask.

The I2C lines are oversampled on the system clock through two-stage synchronizers. SDA is modelled as an open-drain pull-down enable, so a 1 on `sda_oe` pulls the line low. The pads are modelled as separate input, output and output-enable vectors.

Top module: `gpio_expander_i2c`

## Requirements
- R1: After reset, every output enable is 0 (all pins are inputs), SDA is released, output register = 0xFF, inversion register = 0x00, configuration register = 0xFF (1 = input).
- R2: The target address is {ADDR_HI, addr_sel[2:0]}. The block pulls SDA low in the ACK slot only for its own address. For any other address it releases SDA for the whole transfer.
- R3: A write is address+W, a command byte, then data bytes. Every data byte goes to the register that the low two bits of the command select: 1 = output, 2 = inversion, 3 = configuration. The last byte wins.
- R4: pin_oe[i] is 1 exactly when configuration bit i is 0, and pin_o always shows the output register.
- R5: Reading command 0 returns pin_i XOR inversion register, so a set inversion bit reads as the complement of its pin.
- R6: Command 0 is read-only. A data byte written to it is acknowledged and changes no register.
- R7: All four registers can be read through address+W, command byte, repeated START, address+R.
- R8: A read keeps returning the selected register for every byte until the host NACKs. The input port is sampled again in the ACK clock before each byte.
- R9: SDA driven by the block changes only while SCL is low.
- R10: A START or STOP seen in any state aborts the current transfer without writing the partial byte. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample SCL and SDA |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 3 | Low three bits of the target address |
| pin_i | input | 8 | Pin levels seen at the pads |
| pin_o | output | 8 | Output values for the pins |
| pin_oe | output | 8 | Per-pin drive enable, 1 = output |

## Verification
The bench aborts a write half-way through a data byte, once with a repeated START and once with a STOP. A core that committed partial shift contents would change the output pins there. It writes to the read-only input command and then reads back every register, which catches a decoder that lets command 0 fall through to another register. It changes the pins between two bytes of one read to confirm that the input port is resampled per byte. It also uses a mixed inversion mask, which would expose a missing or misplaced XOR. It monitors SDA against SCL throughout the run, because a target that moves SDA while SCL is high creates false START or STOP conditions.

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c #(
  parameter logic [3:0] ADDR_HI = 4'b0111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] addr_sel,
  input  logic [7:0] pin_i,
  output logic [7:0] pin_o,
  output logic [7:0] pin_oe
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } st_t;

  st_t        state;
  logic [2:0] scl_s, sda_s;
  logic [7:0] out_r, pol_r, cfg_r, sr, tx, snap, rd_byte;
  logic [1:0] cmd;
  logic [3:0] cnt;
  logic       rw, host_ack;

  wire scl_rise  =  scl_s[1] & ~scl_s[2];
  wire scl_fall  = ~scl_s[1] &  scl_s[2];
  wire scl_high  =  scl_s[1] &  scl_s[2];
  wire start_det = scl_high & ~sda_s[1] &  sda_s[2];
  wire stop_det  = scl_high &  sda_s[1] & ~sda_s[2];

  assign pin_o  = out_r;
  assign pin_oe = ~cfg_r;

  always_comb begin
    case (cmd)
      2'd0:    rd_byte = snap ^ pol_r;
      2'd1:    rd_byte = out_r;
      2'd2:    rd_byte = pol_r;
      default: rd_byte = cfg_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sda_oe   <= 1'b0;
      out_r    <= 8'hFF;
      pol_r    <= 8'h00;
      cfg_r    <= 8'hFF;
      cmd      <= 2'd0;
      sr       <= 8'h00;
      tx       <= 8'h00;
      snap     <= 8'h00;
      cnt      <= 4'd0;
      rw       <= 1'b0;
      host_ack <= 1'b0;
    end else if (start_det) begin
      state  <= S_ADDR;
      cnt    <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (state)
        S_ADDR, S_CMD, S_WDAT: begin
          sr  <= {sr[6:0], sda_s[1]};
          cnt <= cnt + 4'd1;
        end
        S_AACK: snap <= pin_i;
        S_RACK: begin
          snap     <= pin_i;
          host_ack <= ~sda_s[1];
        end
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state)
        S_ADDR: if (cnt == 4'd8) begin
          cnt <= 4'd0;
          if (sr[7:1] == {ADDR_HI, addr_sel}) begin
            state  <= S_AACK;
            rw     <= sr[0];
            sda_oe <= 1'b1;
          end else begin
            state  <= S_IDLE;
          end
        end
        S_AACK: begin
          cnt    <= 4'd0;
          tx     <= rd_byte;
          sda_oe <= rw ? ~rd_byte[7] : 1'b0;
          state  <= rw ? S_RDAT : S_CMD;
        end
        S_CMD: if (cnt == 4'd8) begin
          cnt    <= 4'd0;
          cmd    <= sr[1:0];
          sda_oe <= 1'b1;
          state  <= S_CACK;
        end
        S_CACK, S_WACK: begin
          sda_oe <= 1'b0;
          state  <= S_WDAT;
        end
        S_WDAT: if (cnt == 4'd8) begin
          cnt    <= 4'd0;
          sda_oe <= 1'b1;
          state  <= S_WACK;
          case (cmd)
            2'd1:    out_r <= sr;
            2'd2:    pol_r <= sr;
            2'd3:    cfg_r <= sr;
            default: ;
          endcase
        end
        S_RDAT: begin
          if (cnt == 4'd7) begin
            cnt    <= 4'd0;
            sda_oe <= 1'b0;
            state  <= S_RACK;
          end else begin
            cnt    <= cnt + 4'd1;
            sda_oe <= ~tx[6];
            tx     <= {tx[6:0], 1'b0};
          end
        end
        S_RACK: begin
          if (host_ack) begin
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            state  <= S_RDAT;
          end else begin
            state  <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_expander_i2c_chk.sv
module gpio_expander_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [7:0] pin_o,
  input logic [7:0] pin_oe,
  input logic [1:0] cmd,
  input logic [3:0] state,
  input logic       start_det
);

  // R1
  reset_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == 8'h00 && !sda_oe));

  // R9
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R3
  out_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_o) |-> $past(cmd) == 2'd1);

  // R4
  cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $past(cmd) == 2'd3);

  // R10
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> state == 4'd1);

  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd0 |-> !sda_oe);

endmodule

bind gpio_expander_i2c gpio_expander_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .pin_o(pin_o), .pin_oe(pin_oe), .cmd(cmd), .state(state),
  .start_det(start_det)
);

// File: tb/sim_gpio_expander_i2c.sv
module sim_gpio_expander_i2c;
  localparam int T = 10;
  localparam logic [7:0] ADW = 8'h7A;
  localparam logic [7:0] ADR = 8'h7B;

  logic clk = 0, rst_n = 0, m_scl = 1, m_low = 0;
  logic [7:0] pin_i = 8'h00;
  logic sda_oe;
  logic [7:0] pin_o, pin_oe;
  wire sda_line = ~(m_low | sda_oe);
  int checks = 0, errors = 0, r9_bad = 0;
  logic prev_oe = 0;

  always #4 clk = ~clk;

  gpio_expander_i2c u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(3'b101), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && m_scl) r9_bad++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_low = 0; wt(T); m_scl = 1; wt(T); m_low = 1; wt(T); m_scl = 0; wt(T);
  endtask

  task automatic i2c_stop;
    m_low = 1; wt(T); m_scl = 1; wt(T); m_low = 0; wt(T);
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b; wt(T); m_scl = 1; wt(T); m_scl = 0; wt(T);
  endtask

  task automatic byte_out(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    m_low = 0; wt(T); m_scl = 1; wt(T / 2); ack = ~sda_line; wt(T / 2); m_scl = 0; wt(T);
  endtask

  task automatic byte_in(input logic nack, input logic upd, input logic [7:0] nv, output logic [7:0] b);
    m_low = 0;
    for (int i = 0; i < 8; i++) begin
      wt(T); m_scl = 1; wt(T / 2); b = {b[6:0], sda_line}; wt(T / 2); m_scl = 0;
    end
    if (upd) pin_i = nv;
    m_low = ~nack; wt(T); m_scl = 1; wt(T); m_scl = 0; wt(T); m_low = 0;
  endtask

  task automatic wr_reg(input logic [7:0] c, input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input int n, output logic all_ack);
    logic a;
    all_ack = 1;
    i2c_start;
    byte_out(ADW, a); all_ack &= a;
    byte_out(c, a); all_ack &= a;
    byte_out(d0, a); all_ack &= a;
    if (n > 1) begin byte_out(d1, a); all_ack &= a; end
    if (n > 2) begin byte_out(d2, a); all_ack &= a; end
    i2c_stop;
  endtask

  task automatic rd_reg(input logic [7:0] c, output logic [7:0] b);
    logic a;
    i2c_start; byte_out(ADW, a); byte_out(c, a);
    i2c_start; byte_out(ADR, a);
    byte_in(1'b1, 1'b0, 8'h00, b);
    i2c_stop;
  endtask

  task automatic t_reset;
    logic [7:0] b;
    chk(pin_oe == 8'h00, "R1 pin_oe", pin_oe, 8'h00);
    chk(sda_line == 1'b1, "R1 sda released", {7'd0, sda_line}, 8'h01);
    chk(pin_o == 8'hFF, "R1 pin_o", pin_o, 8'hFF);
    rd_reg(8'h03, b); chk(b == 8'hFF, "R1 R7 cfg default", b, 8'hFF);
    rd_reg(8'h01, b); chk(b == 8'hFF, "R1 R7 out default", b, 8'hFF);
    rd_reg(8'h02, b); chk(b == 8'h00, "R1 R7 pol default", b, 8'h00);
  endtask

  task automatic t_address;
    logic a;
    i2c_start; byte_out(8'h78, a); i2c_stop;
    chk(a == 1'b0, "R2 foreign address NACK", {7'd0, a}, 8'h00);
    i2c_start; byte_out(ADW, a); i2c_stop;
    chk(a == 1'b1, "R2 own address ACK", {7'd0, a}, 8'h01);
  endtask

  task automatic t_direction;
    logic a;
    logic [7:0] b;
    wr_reg(8'h03, 8'h0F, 8'h00, 8'h00, 1, a);
    chk(a, "R3 cfg write acked", {7'd0, a}, 8'h01);
    chk(pin_oe == 8'hF0, "R4 pin_oe from cfg", pin_oe, 8'hF0);
    wr_reg(8'h01, 8'hA5, 8'h00, 8'h00, 1, a);
    chk(pin_o == 8'hA5, "R3 R4 pin_o", pin_o, 8'hA5);
    rd_reg(8'h01, b); chk(b == 8'hA5, "R7 out readback", b, 8'hA5);
    rd_reg(8'h03, b); chk(b == 8'h0F, "R7 cfg readback", b, 8'h0F);
  endtask

  task automatic t_multi;
    logic a;
    wr_reg(8'h01, 8'h11, 8'h22, 8'h33, 3, a);
    chk(a, "R3 multi-byte acks", {7'd0, a}, 8'h01);
    chk(pin_o == 8'h33, "R3 last byte wins", pin_o, 8'h33);
    chk(pin_oe == 8'hF0, "R3 cfg untouched", pin_oe, 8'hF0);
  endtask

  task automatic t_polarity;
    logic a;
    logic [7:0] b;
    pin_i = 8'h3C;
    wr_reg(8'h02, 8'hF0, 8'h00, 8'h00, 1, a);
    rd_reg(8'h00, b); chk(b == 8'hCC, "R5 inverted input", b, 8'hCC);
    rd_reg(8'h02, b); chk(b == 8'hF0, "R7 pol readback", b, 8'hF0);
  endtask

  task automatic t_readonly;
    logic a;
    logic [7:0] b;
    wr_reg(8'h00, 8'h55, 8'h00, 8'h00, 1, a);
    chk(a, "R6 write to input acked", {7'd0, a}, 8'h01);
    chk(pin_o == 8'h33, "R6 pin_o unchanged", pin_o, 8'h33);
    chk(pin_oe == 8'hF0, "R6 pin_oe unchanged", pin_oe, 8'hF0);
    rd_reg(8'h02, b); chk(b == 8'hF0, "R6 pol unchanged", b, 8'hF0);
  endtask

  task automatic t_repeat;
    logic a;
    logic [7:0] b1, b2;
    i2c_start; byte_out(ADW, a); byte_out(8'h01, a);
    i2c_start; byte_out(ADR, a);
    byte_in(1'b0, 1'b0, 8'h00, b1); byte_in(1'b1, 1'b0, 8'h00, b2); i2c_stop;
    chk(b1 == 8'h33, "R8 repeat byte 1", b1, 8'h33);
    chk(b2 == 8'h33, "R8 repeat byte 2", b2, 8'h33);
    pin_i = 8'h00;
    i2c_start; byte_out(ADW, a); byte_out(8'h00, a);
    i2c_start; byte_out(ADR, a);
    byte_in(1'b0, 1'b1, 8'h81, b1); byte_in(1'b1, 1'b0, 8'h00, b2); i2c_stop;
    chk(b1 == 8'hF0, "R8 input byte 1", b1, 8'hF0);
    chk(b2 == 8'h71, "R8 input resampled", b2, 8'h71);
  endtask

  task automatic t_abort;
    logic a;
    i2c_start; byte_out(ADW, a); byte_out(8'h01, a);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    i2c_start; byte_out(ADW, a);
    chk(a, "R10 repeated start readdress", {7'd0, a}, 8'h01);
    i2c_stop;
    chk(pin_o == 8'h33, "R10 start abort no write", pin_o, 8'h33);
    i2c_start; byte_out(ADW, a); byte_out(8'h01, a);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    i2c_stop;
    chk(pin_o == 8'h33, "R10 stop abort no write", pin_o, 8'h33);
    wr_reg(8'h01, 8'h5A, 8'h00, 8'h00, 1, a);
    chk(pin_o == 8'h5A, "R10 recovery write", pin_o, 8'h5A);
  endtask

  initial begin
    wt(5); rst_n = 1; wt(5);
    t_reset;
    t_address;
    t_direction;
    t_multi;
    t_polarity;
    t_readonly;
    t_repeat;
    t_abort;
    chk(r9_bad == 0, "R9 sda changed with scl high", r9_bad[7:0], 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule